// File: doc/BRIEF.md
# Sparse Mel Band Energy Accumulator

This block turns one frame of a power spectrum into a set of Mel band energies. Spectrum bins (signed 32-bit integers) are loaded into a local buffer through a simple write port while the block is idle. A start pulse then begins a pass. The block walks the bands in ascending order. For each band it fetches the band's first and last non-zero bin from a coefficient ROM. It then multiplies and accumulates only the bins inside that span against the band's triangular weights. Each band produces one energy beat on the output stream, tagged with its band index. A single done pulse follows the final band.

The ROM holds only the span bounds and the non-zero weights. The weights are packed back to back in band order, and a running pointer steps through them one per processed bin. A band whose span is empty consumes no weights and reports zero. Neighbouring bands overlap, so a bin can contribute to two bands. The band count, bin count, word widths and triangle half-width are parameters, and the ROM contents are derived from them at elaboration.

Top module: `mel_band_accum`

## Requirements
- R1: Each band energy equals the sum of bin value times weight over the band's span, arithmetically shifted right by 15 (rounding toward minus infinity). The bin value is treated as signed and the weight as unsigned Q15.
- R2: With half-width H = STEP, band k spans bins k*H to k*H+2H, where that upper bound is clipped to the last bin. The weight at offset j from the span start is min(j+1, 2H+1-j) * floor(32767/(H+1)). As a result, adjacent bands share bins.
- R3: The band numbered EMPTY_BAND is stored with its first index (1) above its last index (0). It reports an energy of exactly 0.
- R4: A shifted sum above 2^31-1 is reported as 2^31-1. A shifted sum below -2^31 is reported as -2^31.
- R5: One pass emits exactly NUM_BANDS single-cycle out_valid beats, with out_band counting 0, 1, ... NUM_BANDS-1 in order.
- R6: done is high for one cycle, exactly one cycle after the out_valid beat of the last band, and once per pass.
- R7: A start pulse that arrives while a pass is running is ignored. It produces no extra beats and no extra done.
- R8: A spectrum write that arrives during a pass is dropped, both for that pass and for later ones. A write in the same cycle as an accepted start is stored and is used by that pass.
- R9: While reset is high and right after it is released, out_valid and done are 0.
- R10: The last bands, whose nominal span runs past the final bin, use only the bins that exist, with the weights of their leading offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass over all bands (honoured only when idle) |
| wr_en | input | 1 | Spectrum buffer write strobe |
| wr_addr | input | BIN_W | Bin index to write |
| wr_data | input | DATA_W | Signed bin value |
| out_valid | output | 1 | One band energy is present |
| out_band | output | BAND_W | Index of the band being reported |
| out_energy | output | DATA_W | Signed saturated band energy |
| done | output | 1 | Pass complete, one-cycle pulse |

## Verification
Two pairs of events can land in the same cycle: a spectrum write together with the start that opens a pass, and a start or a write that arrives while a pass is in progress. The bench drives a write and a start in the same cycle and expects the new value to show up in the affected bands. It also writes and restarts in the middle of a pass, and then expects that pass and the following pass to match the unmodified spectrum, with no extra beats or done pulses. Every output beat is compared with a behavioural model that recomputes each band from the span and weight formulas.

// File: rtl/mel_pkg.sv
package mel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_SETUP, ST_RUN, ST_DRAIN, ST_EMIT, ST_FIN
  } mel_state_t;

  // first bin of band k (empty band stored as 1 > 0)
  function automatic int band_lo(int k, int step, int nbins, int empty_k);
    if (k == empty_k) return 1;
    if (k * step > nbins - 1) return nbins - 1;
    return k * step;
  endfunction

  function automatic int band_hi(int k, int step, int nbins, int empty_k);
    int h;
    if (k == empty_k) return 0;
    h = k * step + 2 * step;
    if (h > nbins - 1) h = nbins - 1;
    return h;
  endfunction

  function automatic int band_len(int k, int step, int nbins, int empty_k);
    int lo;
    int hi;
    lo = band_lo(k, step, nbins, empty_k);
    hi = band_hi(k, step, nbins, empty_k);
    if (lo > hi) return 0;
    return hi - lo + 1;
  endfunction

  function automatic int total_wgts(int nb, int step, int nbins, int empty_k);
    int s;
    s = 0;
    for (int k = 0; k < nb; k++) s += band_len(k, step, nbins, empty_k);
    return s;
  endfunction

  function automatic int tri_shape(int j, int step);
    int a;
    int b;
    a = j + 1;
    b = 2 * step + 1 - j;
    return (a < b) ? a : b;
  endfunction

  // weight stored at packed position g
  function automatic int wgt_at(int g, int nb, int step, int nbins, int empty_k);
    int base;
    int len;
    base = 0;
    for (int k = 0; k < nb; k++) begin
      len = band_len(k, step, nbins, empty_k);
      if (g >= base && g < base + len)
        return tri_shape(g - base, step) * (32767 / (step + 1));
      base += len;
    end
    return 0;
  endfunction

endpackage

// File: rtl/mel_coef_rom.sv
module mel_coef_rom #(
  parameter int NUM_BANDS  = 8,
  parameter int NUM_BINS   = 32,
  parameter int STEP       = 4,
  parameter int EMPTY_BAND = 3,
  parameter int WGT_W      = 16,
  parameter int BAND_W     = 3,
  parameter int BIN_W      = 5,
  parameter int PTR_W      = 6
) (
  input  logic              clk,
  input  logic [BAND_W-1:0] band_addr,
  input  logic [PTR_W-1:0]  wptr,
  output logic [BIN_W-1:0]  lo_q,
  output logic [BIN_W-1:0]  hi_q,
  output logic [WGT_W-1:0]  wgt_q
);
  localparam int BAND_D = 2 ** BAND_W;
  localparam int WGT_D  = 2 ** PTR_W;

  logic [BIN_W-1:0] lo_tab [BAND_D];
  logic [BIN_W-1:0] hi_tab [BAND_D];
  logic [WGT_W-1:0] w_tab  [WGT_D];

  for (genvar k = 0; k < BAND_D; k++) begin : g_span
    if (k < NUM_BANDS) begin : g_real
      assign lo_tab[k] = BIN_W'(mel_pkg::band_lo(k, STEP, NUM_BINS, EMPTY_BAND));
      assign hi_tab[k] = BIN_W'(mel_pkg::band_hi(k, STEP, NUM_BINS, EMPTY_BAND));
    end else begin : g_pad
      assign lo_tab[k] = BIN_W'(1);
      assign hi_tab[k] = '0;
    end
  end

  for (genvar g = 0; g < WGT_D; g++) begin : g_wgt
    assign w_tab[g] = WGT_W'(mel_pkg::wgt_at(g, NUM_BANDS, STEP, NUM_BINS, EMPTY_BAND));
  end

  always_ff @(posedge clk) begin
    lo_q  <= lo_tab[band_addr];
    hi_q  <= hi_tab[band_addr];
    wgt_q <= w_tab[wptr];
  end
endmodule

// File: rtl/mel_spec_buf.sv
module mel_spec_buf #(
  parameter int DATA_W = 32,
  parameter int BIN_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BIN_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BIN_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** BIN_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mel_mac.sv
module mel_mac #(
  parameter int DATA_W = 32,
  parameter int WGT_W  = 16,
  parameter int ACC_W  = 64,
  parameter int FRAC   = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     in_v,
  input  logic signed [DATA_W-1:0] samp,
  input  logic [WGT_W-1:0]         wgt,
  output logic signed [DATA_W-1:0] energy
);
  localparam int PROD_W = DATA_W + WGT_W + 1;
  localparam int TOP_W  = ACC_W - DATA_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  shv;
  logic [TOP_W-1:0]         top_bits;

  assign prod = samp * $signed({1'b0, wgt});

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (in_v)  acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  assign shv      = acc >>> FRAC;
  assign top_bits = shv[ACC_W-1:DATA_W-1];

  always_comb begin
    if ((&top_bits) || !(|top_bits)) energy = shv[DATA_W-1:0];
    else if (shv[ACC_W-1])           energy = {1'b1, {(DATA_W-1){1'b0}}};
    else                             energy = {1'b0, {(DATA_W-1){1'b1}}};
  end

  // R1: a clear with no accumulate leaves an empty sum
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr && !in_v |=> acc == '0);

  // R4: saturation never flips the sign of the sum
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    energy[DATA_W-1] == acc[ACC_W-1]);
endmodule

// File: rtl/mel_band_accum.sv
module mel_band_accum #(
  parameter int NUM_BANDS  = 8,
  parameter int NUM_BINS   = 32,
  parameter int DATA_W     = 32,
  parameter int WGT_W      = 16,
  parameter int ACC_W      = 64,
  parameter int FRAC       = 15,
  parameter int STEP       = 4,
  parameter int EMPTY_BAND = 3,
  parameter int BAND_W     = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1,
  parameter int BIN_W      = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [BIN_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output logic [BAND_W-1:0] out_band,
  output logic [DATA_W-1:0] out_energy,
  output logic              done
);
  import mel_pkg::*;

  localparam int WTOT  = total_wgts(NUM_BANDS, STEP, NUM_BINS, EMPTY_BAND);
  localparam int PTR_W = $clog2(WTOT + 1);
  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

  mel_state_t        st;
  logic [BAND_W-1:0] band;
  logic [BIN_W-1:0]  bin;
  logic [BIN_W-1:0]  hi_r;
  logic [PTR_W-1:0]  wptr;
  logic              iss_v;
  logic              iss_last;

  logic [BIN_W-1:0]  lo_q;
  logic [BIN_W-1:0]  hi_q;
  logic [WGT_W-1:0]  wgt_q;
  logic [DATA_W-1:0] samp_q;
  logic [DATA_W-1:0] energy;
  logic              buf_we;
  logic              mac_clr;

  assign buf_we  = wr_en && (st == ST_IDLE);
  assign mac_clr = (st == ST_EMIT) || (st == ST_IDLE && start);

  mel_coef_rom #(
    .NUM_BANDS(NUM_BANDS), .NUM_BINS(NUM_BINS), .STEP(STEP),
    .EMPTY_BAND(EMPTY_BAND), .WGT_W(WGT_W), .BAND_W(BAND_W),
    .BIN_W(BIN_W), .PTR_W(PTR_W)
  ) u_rom (
    .clk(clk), .band_addr(band), .wptr(wptr),
    .lo_q(lo_q), .hi_q(hi_q), .wgt_q(wgt_q)
  );

  mel_spec_buf #(.DATA_W(DATA_W), .BIN_W(BIN_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(bin), .rdata(samp_q)
  );

  mel_mac #(.DATA_W(DATA_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst(rst), .clr(mac_clr), .in_v(iss_v),
    .samp(samp_q), .wgt(wgt_q), .energy(energy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      band       <= '0;
      bin        <= '0;
      hi_r       <= '0;
      wptr       <= '0;
      iss_v      <= 1'b0;
      iss_last   <= 1'b0;
      out_valid  <= 1'b0;
      out_band   <= '0;
      out_energy <= '0;
      done       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      iss_v     <= 1'b0;
      iss_last  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            band <= '0;
            wptr <= '0;
            st   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: st <= ST_SETUP;
        ST_SETUP: begin
          if (lo_q > hi_q) begin
            st <= ST_EMIT;
          end else begin
            bin  <= lo_q;
            hi_r <= hi_q;
            st   <= ST_RUN;
          end
        end
        ST_RUN: begin
          iss_v    <= 1'b1;
          iss_last <= (bin == hi_r);
          bin      <= bin + 1'b1;
          wptr     <= wptr + 1'b1;
          if (bin == hi_r) st <= ST_DRAIN;
        end
        ST_DRAIN: if (iss_last) st <= ST_EMIT;
        ST_EMIT: begin
          out_valid  <= 1'b1;
          out_band   <= band;
          out_energy <= energy;
          if (band == LAST_BAND) begin
            st <= ST_FIN;
          end else begin
            band <= band + 1'b1;
            st   <= ST_LOOKUP;
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: done only right after the final band beat
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid) && $past(out_band) == LAST_BAND);

  // R5: beats are single-cycle
  a_r5_single_beat: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7: a running pass never restarts from band 0
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_FIN) |=> band >= $past(band));

  // R3: an empty span goes straight to reporting with no MAC work
  a_r3_empty_skip: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETUP && lo_q > hi_q) |=> st == ST_EMIT && !iss_v);

  // R2: the weight pointer stays inside the packed table
  a_r2_ptr_in_table: assert property (@(posedge clk) disable iff (rst)
    iss_v |-> $past(wptr) < PTR_W'(WTOT));
endmodule

// File: tb/tb_mel_band_accum.sv
module tb_mel_band_accum;
  localparam int NB = 8, NBINS = 32, STEP = 4, EMPTY = 3;
  localparam int BAND_W = 3, BIN_W = 5, DW = 32;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr_en = 1'b0;
  logic [BIN_W-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic out_valid, done;
  logic [BAND_W-1:0] out_band;
  logic [DW-1:0] out_energy;

  always #5 clk = ~clk;

  mel_band_accum dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_valid(out_valid), .out_band(out_band),
    .out_energy(out_energy), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  longint spec_m [NBINS];
  longint exp_e [NB];
  bit pass_on = 0, prev_last = 0;
  int nxt = 0;
  int stray = 0;
  string tag = "R1";
  bit finished = 0;

  task automatic check(bit ok, string req, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint model_band(int k);
    int lo, hi, j, t;
    longint s, sh;
    if (k == EMPTY) return 0;
    lo = k * STEP;
    hi = lo + 2 * STEP;
    if (hi > NBINS - 1) hi = NBINS - 1;
    s = 0;
    for (int i = lo; i <= hi; i++) begin
      j = i - lo;
      t = (j + 1 < 2 * STEP + 1 - j) ? j + 1 : 2 * STEP + 1 - j;
      s += spec_m[i] * longint'(t * (32767 / (STEP + 1)));
    end
    sh = s >>> 15;
    if (sh > 64'sd2147483647) return 64'sd2147483647;
    if (sh < -64'sd2147483648) return -64'sd2147483648;
    return sh;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (!pass_on) begin
          stray++;
          check(0, "R7", longint'(out_band), -1);
        end else begin
          check(int'(out_band) == nxt, "R5", longint'(out_band), longint'(nxt));
          check(longint'($signed(out_energy)) == exp_e[out_band], tag,
                longint'($signed(out_energy)), exp_e[out_band]);
          nxt++;
        end
      end
      if (done) begin
        check(pass_on && nxt == NB && prev_last, "R6", longint'(nxt), longint'(NB));
        pass_on = 0;
      end
      prev_last = out_valid && (int'(out_band) == NB - 1);
    end
  end

  task automatic write_bin(int a, longint v);
    @(negedge clk);
    wr_en = 1; wr_addr = BIN_W'(a); wr_data = DW'(v);
    if (!pass_on) spec_m[a] = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic arm();
    for (int k = 0; k < NB; k++) exp_e[k] = model_band(k);
    nxt = 0;
    pass_on = 1;
  endtask

  task automatic run_pass(string t);
    tag = t;
    @(negedge clk);
    start = 1;
    arm();
    @(negedge clk);
    start = 0;
    wait_idle();
  endtask

  task automatic wait_idle();
    int c;
    c = 0;
    while (pass_on && c < 3000) begin
      @(negedge clk);
      c++;
    end
    if (pass_on) begin
      check(0, "R6", 0, 1);
      pass_on = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && done == 0, "R9", longint'(out_valid), 0);
    rst = 0;
    @(negedge clk);
    check(out_valid == 0 && done == 0, "R9", longint'(done), 0);

    // ramp (R1, R2, R3, R5, R6, R10)
    for (int i = 0; i < NBINS; i++) write_bin(i, longint'(i * 1000 + 7));
    run_pass("R1");

    // mixed signs, floor on negative sums (R1)
    for (int i = 0; i < NBINS; i++)
      write_bin(i, (i % 3 == 0) ? -longint'(i * 777 + 1) : longint'(i * 55));
    run_pass("R1");

    // impulse on a bin shared by bands 0 and 1 (R2)
    for (int i = 0; i < NBINS; i++) write_bin(i, 0);
    write_bin(4, 123456);
    run_pass("R2");

    // impulse on the final bin, clipped bands (R10)
    write_bin(4, 0);
    write_bin(NBINS - 1, 99999);
    run_pass("R10");

    // positive then negative saturation (R4)
    for (int i = 0; i < NBINS; i++) write_bin(i, 64'sd2147483647);
    run_pass("R4");
    for (int i = 0; i < NBINS; i++) write_bin(i, -64'sd2147483648);
    run_pass("R4");

    // write in the same cycle as start is used (R8)
    for (int i = 0; i < NBINS; i++) write_bin(i, longint'(i + 1));
    tag = "R8";
    @(negedge clk);
    start = 1; wr_en = 1; wr_addr = BIN_W'(9); wr_data = DW'(500000);
    spec_m[9] = 500000;
    arm();
    @(negedge clk);
    start = 0; wr_en = 0;
    // mid-pass write is dropped and mid-pass start is ignored (R8, R7)
    repeat (6) @(negedge clk);
    wr_en = 1; wr_addr = BIN_W'(9); wr_data = DW'(-7);
    @(negedge clk);
    wr_en = 0;
    repeat (10) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
    repeat (150) @(negedge clk);
    check(stray == 0, "R7", longint'(stray), 0);
    run_pass("R8");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule